// File: doc/BRIEF.md
# Free-Running Cycle Interrupt Timer

The block raises a periodic interrupt request from a 16-bit up-counter that advances once for every CPU bus cycle, signalled by a one-cycle `m2_tick` strobe. It has no compare or reload value. The request is simply bit 10 of the counter while the timer runs. It is therefore high for 1024 bus cycles, low for the next 1024, and repeats with a 2048-cycle period until software stops it.

Software controls the block through bus writes that land in the top quarter of the address space, where the two most significant address bits are both 1. Only data bit 2 of such a write matters; call it the hold bit. Writing it as 1 acknowledges the interrupt, clears the counter and keeps it at zero. Writing it as 0 clears the counter and lets it count.

A write-protect flag is set by reset and is cleared the first time the timer is released from the held state. It is offered as an output so that a neighbouring memory controller can use it.

The control is a two-state machine:
- HELD: the counter is pinned at 0 and the interrupt is low. This is the reset state.
- RUNNING: the counter counts.

There are four transitions:
- STAY_HELD: HELD to HELD, on no write or on a hold=1 write.
- RELEASE: HELD to RUNNING, on a hold=0 write. It clears the protect flag.
- RESTART: RUNNING to RUNNING, on a hold=0 write. The counter returns to 0.
- ACK: RUNNING to HELD, on a hold=1 write.

Top module: `cyc_irq_timer`

## Requirements
- R1: A control write is a cycle with `cpu_wr`=1 and `cpu_addr[15:14]`=2'b11, and only `cpu_data[2]` (the hold bit) acts. Writes with any other value of `cpu_addr[15:14]` change nothing, and the other data bits have no effect.
- R2: After a control write with hold=1, `count` reads 0 on the next cycle and stays at 0 whatever `m2_tick` does. `irq` stays low.
- R3: After a control write with hold=0, `count` reads 0 on the next cycle. It then increases by 1 on each clock cycle in which `m2_tick`=1 and holds in cycles where `m2_tick`=0.
- R4: While running, `irq` is 1 exactly when `count[10]`=1, so it first goes high on the cycle after the 1024th tick following a release. `irq` is always 0 while held.
- R5: While running, `irq` falls after the 2048th tick and rises again after the 3072nd, repeating every 2048 ticks.
- R6: The counter is 16 bits wide. After 65536 ticks it reads 0 and keeps counting.
- R7: While reset is asserted and after its release, the block is held, with `count`=0, `irq`=0 and `ram_protect`=1.
- R8: `ram_protect` is cleared by a hold=0 control write made while held. Hold=0 writes made while running and all hold=1 writes leave it unchanged, and only reset sets it.
- R9: A control write in the same cycle as a tick takes priority, so `count` reads exactly 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2_tick | input | 1 | One strobe per CPU bus cycle; advances the counter |
| cpu_wr | input | 1 | Bus write strobe |
| cpu_addr | input | 16 | Bus address |
| cpu_data | input | 8 | Bus write data |
| irq | output | 1 | Registered active-high interrupt request |
| ram_protect | output | 1 | Write-protect flag, set by reset |
| count | output | 16 | Current counter value |

## Verification
Writes are tried in the lower three quarters of the address space and with the hold bit set or clear among all-ones data. These tell a correct decode apart from one that looks at the wrong address or data bits. Long runs with a tick on every cycle pin the exact cycles of the first rise, the fall, the second rise and the 16-bit wrap. A run with a tick on alternate cycles separates counting per tick from counting per clock. Release, restart and acknowledge writes are issued together with a tick to show that the write wins, and reset is applied mid-run to confirm that the protect flag returns.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int CIT_CNT_W   = 16;
    localparam int CIT_IRQ_BIT = 10;
    localparam int CIT_HOLD_BIT = 2;
    localparam int CIT_ADDR_W  = 16;
    localparam int CIT_DATA_W  = 8;
    localparam int CIT_SEL_W   = 2;
    localparam logic [CIT_SEL_W-1:0] CIT_SEL_VAL = 2'b11;

    typedef enum logic {
        ST_HELD    = 1'b0,
        ST_RUNNING = 1'b1
    } tmr_state_t;
endpackage

// File: rtl/cit_decode.sv
module cit_decode #(
    parameter int ADDR_W   = cit_pkg::CIT_ADDR_W,
    parameter int DATA_W   = cit_pkg::CIT_DATA_W,
    parameter int SEL_W    = cit_pkg::CIT_SEL_W,
    parameter logic [SEL_W-1:0] SEL_VAL = cit_pkg::CIT_SEL_VAL,
    parameter int HOLD_BIT = cit_pkg::CIT_HOLD_BIT
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ctl_wr_o,
    output logic              hold_o
);
    localparam int LOW_ADDR_W = ADDR_W - SEL_W;

    logic [SEL_W-1:0] sel_bits;
    logic             unused_bits;

    assign sel_bits = addr_i[ADDR_W-1 -: SEL_W];

    always_comb begin
        ctl_wr_o = wr_i && (sel_bits == SEL_VAL);
        hold_o   = data_i[HOLD_BIT];
    end

    // Lower address bits and non-hold data bits play no part in the decode.
    assign unused_bits = ^{addr_i[LOW_ADDR_W-1:0], data_i};
endmodule

// File: rtl/cit_fsm.sv
module cit_fsm
    import cit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr_i,
    input  logic       hold_i,
    output tmr_state_t state_o,
    output tmr_state_t state_nx_o,
    output logic       prot_o
);
    tmr_state_t st_q, st_d;
    logic       release_w;
    logic       prot_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HELD;
        else        st_q <= st_d;
    end

    // Next state and transition decode
    always_comb begin
        st_d      = st_q;
        release_w = 1'b0;
        unique case (st_q)
            ST_HELD: begin
                if (ctl_wr_i && !hold_i) begin
                    st_d      = ST_RUNNING;
                    release_w = 1'b1;
                end
            end
            ST_RUNNING: begin
                if (ctl_wr_i && hold_i) st_d = ST_HELD;
            end
            default: st_d = ST_HELD;
        endcase
    end

    // Output register: protect flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prot_q <= 1'b1;
        else if (release_w) prot_q <= 1'b0;
    end

    assign state_o    = st_q;
    assign state_nx_o = st_d;
    assign prot_o     = prot_q;

    // R8
    prot_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_q |=> !prot_q);

    // R8
    prot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUNNING) |=> $stable(prot_q));

    // R2
    ack_to_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && hold_i) |=> (st_q == ST_HELD));
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
    parameter int CNT_W = cit_pkg::CIT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nx_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (clr_i)               cnt_d = '0;
        else if (run_i && tick_i) cnt_d = cnt_q + CNT_W'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o    = cnt_q;
    assign cnt_nx_o = cnt_d;

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2
    held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (cnt_q == '0));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !clr_i && (cnt_q == '1)) |=> (cnt_q == '0));
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cit_pkg::*;
#(
    parameter int CNT_W   = CIT_CNT_W,
    parameter int IRQ_BIT = CIT_IRQ_BIT,
    parameter int ADDR_W  = CIT_ADDR_W,
    parameter int DATA_W  = CIT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2_tick,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              irq,
    output logic              ram_protect,
    output logic [CNT_W-1:0]  count
);
    logic             ctl_wr, hold;
    tmr_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             irq_q;

    cit_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .wr_i     (cpu_wr),
        .addr_i   (cpu_addr),
        .data_i   (cpu_data),
        .ctl_wr_o (ctl_wr),
        .hold_o   (hold)
    );

    cit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_i   (ctl_wr),
        .hold_i     (hold),
        .state_o    (st),
        .state_nx_o (st_nx),
        .prot_o     (ram_protect)
    );

    cit_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ctl_wr),
        .run_i    (st == ST_RUNNING),
        .tick_i   (m2_tick),
        .cnt_o    (cnt),
        .cnt_nx_o (cnt_nx)
    );

    // The request flop looks at next-state values so it moves on the same edge as the counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (st_nx == ST_RUNNING) && cnt_nx[IRQ_BIT];
    end

    assign irq   = irq_q;
    assign count = cnt;

    // R4
    irq_tracks_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == ((st == ST_RUNNING) && cnt[IRQ_BIT]));

    // R4
    irq_low_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HELD) |-> !irq_q);
endmodule

// File: tb/cyc_irq_timer_test.sv
`timescale 1ns/1ps
module cyc_irq_timer_test;
    typedef struct {
        logic        irq;
        logic        prot;
        logic [15:0] cnt;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m2_tick = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        irq, ram_protect;
    logic [15:0] count;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // independent model state
    logic [15:0] m_cnt = '0;
    logic        m_run = 1'b0;
    logic        m_prot = 1'b1;

    always #10 clk = ~clk;

    cyc_irq_timer uut (
        .clk (clk), .rst_n (rst_n), .m2_tick (m2_tick), .cpu_wr (cpu_wr),
        .cpu_addr (cpu_addr), .cpu_data (cpu_data), .irq (irq),
        .ram_protect (ram_protect), .count (count)
    );

    function automatic exp_t mk(string tag);
        exp_t e;
        e.irq  = m_run && m_cnt[10];
        e.prot = m_prot;
        e.cnt  = m_cnt;
        e.tag  = tag;
        return e;
    endfunction

    task automatic step(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        input logic tk, input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        cpu_wr = wr; cpu_addr = a; cpu_data = d; m2_tick = tk;
        if (wr && a[15:14] == 2'b11) begin
            if (!d[2] && !m_run) m_prot = 1'b0;
            m_run = !d[2];
            m_cnt = '0;
        end else if (m_run && tk) begin
            m_cnt = m_cnt + 16'd1;
        end
        sb_q.push_back(mk(tag));
    endtask

    task automatic run(input int n, input logic tk, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 8'h00, tk, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; cpu_wr = 1'b0; m2_tick = 1'b1;
        m_cnt = '0; m_run = 1'b0; m_prot = 1'b1;
        sb_q.push_back(mk(tag));
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (irq !== e.irq || ram_protect !== e.prot || count !== e.cnt) begin
                    n_fail++;
                    $display("FAIL %s: irq/prot/count actual %b/%b/%0d expected %b/%b/%0d",
                             e.tag, irq, ram_protect, count, e.irq, e.prot, e.cnt);
                end
            end
        end
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: reset state held for a few cycles, then idle ticks while held
        do_reset("R7");
        do_reset("R7");
        run(10, 1'b1, "R7");
        // R1: writes outside the control range, and to it with other bits set
        step(1'b1, 16'h8000, 8'h00, 1'b1, "R1");
        run(5, 1'b1, "R1");
        step(1'b1, 16'hBFFF, 8'h00, 1'b1, "R1");
        step(1'b1, 16'h4000, 8'h00, 1'b1, "R1");
        run(5, 1'b1, "R1");
        // R8: release with all other data bits set clears protect
        step(1'b1, 16'hC000, 8'hFB, 1'b1, "R8");
        // R4: first rise after 1024 ticks
        run(1100, 1'b1, "R4");
        // R5: fall at 2048, rise at 3072
        run(2000, 1'b1, "R5");
        // R2: acknowledge
        step(1'b1, 16'hFFFF, 8'h04, 1'b1, "R2");
        run(20, 1'b1, "R2");
        step(1'b1, 16'hE123, 8'hFF, 1'b1, "R2");
        run(5, 1'b1, "R2");
        // R9: release with a tick in the same cycle
        step(1'b1, 16'hC000, 8'h00, 1'b1, "R9");
        run(300, 1'b1, "R3");
        // R9 + R8: restart while running keeps protect clear
        step(1'b1, 16'hD000, 8'h00, 1'b1, "R9");
        // R3: tick on alternate cycles
        for (int i = 0; i < 2200; i++) step(1'b0, 16'h0000, 8'h00, logic'(i % 2), "R3");
        step(1'b1, 16'hF000, 8'h04, 1'b1, "R9");
        // R6: wrap past 65536 ticks
        step(1'b1, 16'hC000, 8'h00, 1'b1, "R6");
        run(65536 + 200, 1'b1, "R6");
        // R7: reset mid-run restores protect
        do_reset("R7");
        run(10, 1'b1, "R7");
        step(1'b0, 16'h0000, 8'h00, 1'b0, "R7");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule